// File: doc/BRIEF.md
# Two-Beat Double-Data-Rate SRAM Protocol Engine

This block is the device-side control logic of a synchronous SRAM that moves data on both clock phases and transfers two words per address. It runs from one internal clock at twice the rate of the external K clock. An internal phase bit marks which internal cycles correspond to a K rise and which to a K-bar rise. On every K cycle it samples an active-low command strobe, a read/write select and a shared address. Each address holds a pair of words, which always move as a burst: the first word, then the second.

Write data follows its address by one K cycle. The two beats come in on consecutive internal cycles, and each beat has its own active-low byte-lane enables. A completed write burst waits one more edge in a posting buffer before it is stored. Reads that reach the array in the meantime see the buffered data, merged lane by lane. Read data leaves the block two and a half K cycles after its address, with a valid flag that covers exactly the two data cycles. The block also drives an echo-clock enable, which stays on whenever it is out of reset.

Top module: `ddr2b_sram_engine`

## Requirements
- R1: `kphase` is 1 in the first internal cycle after reset is released and then alternates every cycle. An operation is sampled only in a cycle with `kphase`=1 and `cmd_n`=0. `is_read`=1 starts a read and `is_read`=0 starts a write.
- R2: For a write sampled in cycle c, word 0 is taken from `wdata` in cycle c+2 and word 1 in cycle c+3. A later read of that address returns both words.
- R3: For a read sampled in cycle c, word 0 is on `rdata` in cycle c+6 and word 1 in cycle c+7.
- R4: `lane_we_n` is active low and is sampled with each write beat. Bit i gates `wdata[i*LANE_W +: LANE_W]` of that beat only. A lane whose bit is 1 keeps its previous contents.
- R5: `rdata_vld` is 1 exactly in the two cycles that carry read data and 0 in every other cycle.
- R6: An operation may be issued on every K cycle, in any mix of reads and writes, with no stall. Each read returns the data of all writes sampled before it.
- R7: A read sampled on the K cycle directly after a write to the same address returns that write's data, merged per lane with the older contents.
- R8: A K cycle with `cmd_n`=1 starts nothing. It raises no valid flag, and `wdata`/`lane_we_n` outside a write's beat cycles change no stored word.
- R9: While `rdata_vld` is 0, `rdata` equals `IDLE_WORD` (0 by default). `echo_en` is 1 from the second cycle after reset release onward.
- R10: Synchronous reset clears the valid flag, `echo_en` and any read in flight. Stored words written before the reset survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate |
| rst | input | 1 | Synchronous active-high reset |
| cmd_n | input | 1 | Active-low operation strobe, sampled on K cycles |
| is_read | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Burst address |
| lane_we_n | input | LANES | Active-low byte-lane write enables, one per beat |
| wdata | input | LANES*LANE_W | Write data beat |
| rdata | output | LANES*LANE_W | Read data beat, `IDLE_WORD` when not valid |
| rdata_vld | output | 1 | Read data valid |
| kphase | output | 1 | 1 in cycles that end on a K rise |
| echo_en | output | 1 | Echo-clock enable |

## Verification
The two functions that can fall in the same cycle are the commit of a posted write burst into the array and the array lookup of a read issued on the very next K cycle. At that edge the array still holds the old word, and only the posting buffer holds the new one. The bench provokes this by pairing every write with an immediate read of the same address while sweeping all sixteen combinations of per-beat lane masks. It judges each returned beat against a lane-merged model that is updated in issue order.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;

   // operation carried down the command pipe
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } ddr2b_op_e;

   // internal edges from the address edge to the first write beat and to the read lookup
   localparam int CMD_LAG = 2;
   // internal edges from the address edge to the edge that drives read word 0
   localparam int RD_EDGE_LAT = 5;

endpackage

// File: rtl/ddr2b_phase.sv
module ddr2b_phase (
   input  logic clk,
   input  logic rst,
   output logic kphase,
   output logic echo_en
);
   logic kph_q;
   logic echo_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         kph_q  <= 1'b1;
         echo_q <= 1'b0;
      end else begin
         kph_q  <= ~kph_q;
         echo_q <= 1'b1;
      end
   end

   assign kphase  = kph_q;
   assign echo_en = echo_q;
endmodule

// File: rtl/ddr2b_cmd.sv
module ddr2b_cmd
   import ddr2b_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            kphase,
   input  logic            cmd_n,
   input  logic            is_read,
   input  logic [AW-1:0]   addr,
   output ddr2b_op_e       lag_op,
   output logic [AW-1:0]   lag_addr
);
   ddr2b_op_e     op_q [CMD_LAG];
   logic [AW-1:0] ad_q [CMD_LAG];
   ddr2b_op_e     op_in;

   always_comb begin
      op_in = OP_NONE;
      if (kphase && !cmd_n)
         op_in = is_read ? OP_READ : OP_WRITE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < CMD_LAG; i++) begin
            op_q[i] <= OP_NONE;
            ad_q[i] <= '0;
         end
      end else begin
         op_q[0] <= op_in;
         ad_q[0] <= addr;
         for (int i = 1; i < CMD_LAG; i++) begin
            op_q[i] <= op_q[i-1];
            ad_q[i] <= ad_q[i-1];
         end
      end
   end

   assign lag_op   = op_q[CMD_LAG-1];
   assign lag_addr = ad_q[CMD_LAG-1];
endmodule

// File: rtl/ddr2b_wpost.sv
module ddr2b_wpost
   import ddr2b_pkg::*;
#(
   parameter int AW     = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int W     = LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst,
   input  ddr2b_op_e          lag_op,
   input  logic [AW-1:0]      lag_addr,
   input  logic [W-1:0]       wdata,
   input  logic [LANES-1:0]   lane_we_n,
   output logic               full,
   output logic [AW-1:0]      p_addr,
   output logic [W-1:0]       p_w0,
   output logic [W-1:0]       p_w1,
   output logic [LANES-1:0]   p_en0,
   output logic [LANES-1:0]   p_en1
);
   logic wait_b1;
   logic full_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         wait_b1 <= 1'b0;
         full_q  <= 1'b0;
      end else begin
         wait_b1 <= (lag_op == OP_WRITE);
         full_q  <= wait_b1;
      end
   end

   always_ff @(posedge clk) begin
      if (lag_op == OP_WRITE) begin
         p_addr <= lag_addr;
         p_w0   <= wdata;
         p_en0  <= ~lane_we_n;
      end
      if (wait_b1) begin
         p_w1  <= wdata;
         p_en1 <= ~lane_we_n;
      end
   end

   assign full = full_q;
endmodule

// File: rtl/ddr2b_store.sv
module ddr2b_store #(
   parameter int AW     = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int W     = LANES * LANE_W,
   localparam int DEPTH = 1 << AW
) (
   input  logic               clk,
   input  logic               we,
   input  logic [AW-1:0]      wa,
   input  logic [W-1:0]       wd0,
   input  logic [W-1:0]       wd1,
   input  logic [LANES-1:0]   wen0,
   input  logic [LANES-1:0]   wen1,
   input  logic [AW-1:0]      ra,
   output logic [W-1:0]       rd0,
   output logic [W-1:0]       rd1
);
   logic [W-1:0] mem0 [DEPTH];
   logic [W-1:0] mem1 [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         for (int l = 0; l < LANES; l++) begin
            if (wen0[l]) mem0[wa][l*LANE_W +: LANE_W] <= wd0[l*LANE_W +: LANE_W];
            if (wen1[l]) mem1[wa][l*LANE_W +: LANE_W] <= wd1[l*LANE_W +: LANE_W];
         end
      end
   end

   assign rd0 = mem0[ra];
   assign rd1 = mem1[ra];
endmodule

// File: rtl/ddr2b_rdpath.sv
module ddr2b_rdpath
   import ddr2b_pkg::*;
#(
   parameter int AW     = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int W     = LANES * LANE_W,
   parameter logic [W-1:0] IDLE_WORD = '0,
   localparam int NSTG  = RD_EDGE_LAT - CMD_LAG
) (
   input  logic               clk,
   input  logic               rst,
   input  ddr2b_op_e          lag_op,
   input  logic [AW-1:0]      lag_addr,
   input  logic [W-1:0]       arr_w0,
   input  logic [W-1:0]       arr_w1,
   input  logic               p_full,
   input  logic [AW-1:0]      p_addr,
   input  logic [W-1:0]       p_w0,
   input  logic [W-1:0]       p_w1,
   input  logic [LANES-1:0]   p_en0,
   input  logic [LANES-1:0]   p_en1,
   output logic [W-1:0]       rdata,
   output logic               rdata_vld
);
   typedef struct packed {
      logic         v;
      logic [W-1:0] w0;
      logic [W-1:0] w1;
   } rstg_t;

   logic         hit;
   logic [W-1:0] lk_w0;
   logic [W-1:0] lk_w1;
   rstg_t        stg [NSTG];
   logic         hold_v;
   logic [W-1:0] hold_w;
   logic [W-1:0] out_q;
   logic         vld_q;

   assign hit = p_full && (p_addr == lag_addr);

   for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign lk_w0[l*LANE_W +: LANE_W] = (hit && p_en0[l]) ? p_w0[l*LANE_W +: LANE_W]
                                                             : arr_w0[l*LANE_W +: LANE_W];
      assign lk_w1[l*LANE_W +: LANE_W] = (hit && p_en1[l]) ? p_w1[l*LANE_W +: LANE_W]
                                                             : arr_w1[l*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NSTG; i++) stg[i] <= '0;
         hold_v <= 1'b0;
         hold_w <= '0;
         out_q  <= IDLE_WORD;
         vld_q  <= 1'b0;
      end else begin
         stg[0].v  <= (lag_op == OP_READ);
         stg[0].w0 <= lk_w0;
         stg[0].w1 <= lk_w1;
         for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
         hold_v <= stg[NSTG-1].v;
         hold_w <= stg[NSTG-1].w1;
         vld_q  <= hold_v | stg[NSTG-1].v;
         if (hold_v)
            out_q <= hold_w;
         else if (stg[NSTG-1].v)
            out_q <= stg[NSTG-1].w0;
         else
            out_q <= IDLE_WORD;
      end
   end

   assign rdata     = out_q;
   assign rdata_vld = vld_q;
endmodule

// File: rtl/ddr2b_sram_engine.sv
module ddr2b_sram_engine
   import ddr2b_pkg::*;
#(
   parameter int AW     = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 9,
   localparam int W     = LANES * LANE_W,
   parameter logic [W-1:0] IDLE_WORD = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               cmd_n,
   input  logic               is_read,
   input  logic [AW-1:0]      addr,
   input  logic [LANES-1:0]   lane_we_n,
   input  logic [W-1:0]       wdata,
   output logic [W-1:0]       rdata,
   output logic               rdata_vld,
   output logic               kphase,
   output logic               echo_en
);
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("ddr2b_sram_engine: AW must lie in 1..12");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("ddr2b_sram_engine: LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("ddr2b_sram_engine: LANE_W must be at least 1");
   end
   if (RD_EDGE_LAT <= CMD_LAG) begin : g_bad_lat
      $error("ddr2b_sram_engine: read latency must exceed the command lag");
   end

   ddr2b_op_e          lag_op;
   logic [AW-1:0]      lag_addr;
   logic               p_full;
   logic [AW-1:0]      p_addr;
   logic [W-1:0]       p_w0;
   logic [W-1:0]       p_w1;
   logic [LANES-1:0]   p_en0;
   logic [LANES-1:0]   p_en1;
   logic [W-1:0]       arr_w0;
   logic [W-1:0]       arr_w1;

   ddr2b_phase u_phase (
      .clk     (clk),
      .rst     (rst),
      .kphase  (kphase),
      .echo_en (echo_en)
   );

   ddr2b_cmd #(.AW(AW)) u_cmd (
      .clk      (clk),
      .rst      (rst),
      .kphase   (kphase),
      .cmd_n    (cmd_n),
      .is_read  (is_read),
      .addr     (addr),
      .lag_op   (lag_op),
      .lag_addr (lag_addr)
   );

   ddr2b_wpost #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wpost (
      .clk       (clk),
      .rst       (rst),
      .lag_op    (lag_op),
      .lag_addr  (lag_addr),
      .wdata     (wdata),
      .lane_we_n (lane_we_n),
      .full      (p_full),
      .p_addr    (p_addr),
      .p_w0      (p_w0),
      .p_w1      (p_w1),
      .p_en0     (p_en0),
      .p_en1     (p_en1)
   );

   ddr2b_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
      .clk  (clk),
      .we   (p_full),
      .wa   (p_addr),
      .wd0  (p_w0),
      .wd1  (p_w1),
      .wen0 (p_en0),
      .wen1 (p_en1),
      .ra   (lag_addr),
      .rd0  (arr_w0),
      .rd1  (arr_w1)
   );

   ddr2b_rdpath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W), .IDLE_WORD(IDLE_WORD)) u_rdpath (
      .clk       (clk),
      .rst       (rst),
      .lag_op    (lag_op),
      .lag_addr  (lag_addr),
      .arr_w0    (arr_w0),
      .arr_w1    (arr_w1),
      .p_full    (p_full),
      .p_addr    (p_addr),
      .p_w0      (p_w0),
      .p_w1      (p_w1),
      .p_en0     (p_en0),
      .p_en1     (p_en1),
      .rdata     (rdata),
      .rdata_vld (rdata_vld)
   );
endmodule

// File: rtl/ddr2b_chk.sv
module ddr2b_chk #(
   parameter int W = 18,
   parameter logic [W-1:0] IDLE_WORD = '0
) (
   input logic         clk,
   input logic         rst,
   input logic         cmd_n,
   input logic         is_read,
   input logic [W-1:0] rdata,
   input logic         rdata_vld,
   input logic         kphase,
   input logic         echo_en
);
   // R1
   kphase_alt_chk: assert property (@(posedge clk) disable iff (rst)
      kphase |=> !kphase);

   // R1
   kbar_alt_chk: assert property (@(posedge clk) disable iff (rst)
      !kphase |=> kphase);

   // R3
   rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
      (kphase && !cmd_n && is_read) |-> ##6 (rdata_vld ##1 rdata_vld));

   // R5
   vld_src_chk: assert property (@(posedge clk) disable iff (rst)
      (rdata_vld && kphase) |-> $past(kphase && !cmd_n && is_read, 6));

   // R5
   vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rdata_vld) |-> kphase);

   // R8
   noop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (kphase && (cmd_n || !is_read)) |-> ##6 (!rdata_vld ##1 !rdata_vld));

   // R9
   idle_word_chk: assert property (@(posedge clk) disable iff (rst)
      !rdata_vld |-> (rdata == IDLE_WORD));

   // R9
   echo_on_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> echo_en);

   // R10
   rst_clear_chk: assert property (@(posedge clk)
      rst |=> (!rdata_vld && !echo_en));
endmodule

bind ddr2b_sram_engine ddr2b_chk #(.W(W), .IDLE_WORD(IDLE_WORD)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .cmd_n     (cmd_n),
   .is_read   (is_read),
   .rdata     (rdata),
   .rdata_vld (rdata_vld),
   .kphase    (kphase),
   .echo_en   (echo_en)
);

// File: tb/sim_ddr2b_sram_engine.sv
module sim_ddr2b_sram_engine;
   localparam int AW    = 4;
   localparam int LANES = 2;
   localparam int LW    = 9;
   localparam int W     = LANES * LW;
   localparam int DEPTH = 1 << AW;
   localparam int MAXS  = 128;
   localparam int MAXC  = 2 * MAXS + 16;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic             rst = 1'b1;
   logic             cmd_n = 1'b1;
   logic             is_read = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [LANES-1:0] lane_we_n = '1;
   logic [W-1:0]     wdata = '0;
   logic [W-1:0]     rdata;
   logic             rdata_vld;
   logic             kphase;
   logic             echo_en;

   ddr2b_sram_engine u0 (
      .clk       (clk),
      .rst       (rst),
      .cmd_n     (cmd_n),
      .is_read   (is_read),
      .addr      (addr),
      .lane_we_n (lane_we_n),
      .wdata     (wdata),
      .rdata     (rdata),
      .rdata_vld (rdata_vld),
      .kphase    (kphase),
      .echo_en   (echo_en)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit finished = 0;

   // slot script for one segment
   bit               s_act [MAXS];
   bit               s_rd  [MAXS];
   logic [AW-1:0]    s_ad  [MAXS];
   logic [W-1:0]     s_d0  [MAXS];
   logic [W-1:0]     s_d1  [MAXS];
   logic [LANES-1:0] s_m0  [MAXS];
   logic [LANES-1:0] s_m1  [MAXS];
   int               nslots;

   // expected outputs per segment cycle
   bit               e_v   [MAXC];
   logic [W-1:0]     e_q   [MAXC];
   string            e_tag [MAXC];

   // reference contents in issue order
   logic [W-1:0]     mdl0 [DEPTH];
   logic [W-1:0]     mdl1 [DEPTH];

   logic [31:0] rs = 32'h1ACE_5EED;

   function automatic logic [31:0] rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   function automatic logic [W-1:0] lane_mix(input logic [W-1:0] old_w,
                                             input logic [W-1:0] new_w,
                                             input logic [LANES-1:0] m_n);
      logic [W-1:0] r = old_w;
      for (int l = 0; l < LANES; l++)
         if (!m_n[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic seg_begin();
      nslots = 0;
      for (int c = 0; c < MAXC; c++) begin
         e_v[c] = 1'b0;
         e_q[c] = '0;
         e_tag[c] = "R3";
      end
   endtask

   task automatic add_slot(input bit act, input bit rd, input int ad,
                           input logic [W-1:0] d0, input logic [LANES-1:0] m0,
                           input logic [W-1:0] d1, input logic [LANES-1:0] m1,
                           input string tag);
      int i = nslots;
      s_act[i] = act;
      s_rd[i]  = rd;
      s_ad[i]  = AW'(ad);
      s_d0[i]  = d0;
      s_d1[i]  = d1;
      s_m0[i]  = m0;
      s_m1[i]  = m1;
      if (act && rd) begin
         e_v[2*i+6] = 1'b1; e_q[2*i+6] = mdl0[AW'(ad)]; e_tag[2*i+6] = tag;
         e_v[2*i+7] = 1'b1; e_q[2*i+7] = mdl1[AW'(ad)]; e_tag[2*i+7] = tag;
      end else if (act) begin
         mdl0[AW'(ad)] = lane_mix(mdl0[AW'(ad)], d0, m0);
         mdl1[AW'(ad)] = lane_mix(mdl1[AW'(ad)], d1, m1);
      end
      nslots++;
   endtask

   // runs the script; the first cycle must be a K cycle
   task automatic run_seg();
      for (int c = 0; c < 2 * nslots + 8; c++) begin
         @(negedge clk);
         check("R5", 32'(rdata_vld), 32'(e_v[c]));
         if (e_v[c]) check(e_tag[c], 32'(rdata), 32'(e_q[c]));
         else        check("R9", 32'(rdata), 32'd0);
         check("R1", 32'(kphase), 32'((c % 2) == 0));
         if (c > 0) check("R9", 32'(echo_en), 32'd1);
         if ((c % 2) == 0 && (c / 2) < nslots) begin
            cmd_n   = !s_act[c/2];
            is_read = s_rd[c/2];
            addr    = s_ad[c/2];
         end else begin
            cmd_n   = 1'b1;
            is_read = rnd() & 1;
            addr    = AW'(rnd());
         end
         if ((c % 2) == 0 && c >= 2 && ((c-2)/2) < nslots && s_act[(c-2)/2] && !s_rd[(c-2)/2]) begin
            wdata     = s_d0[(c-2)/2];
            lane_we_n = s_m0[(c-2)/2];
         end else if ((c % 2) == 1 && c >= 3 && ((c-3)/2) < nslots && s_act[(c-3)/2] && !s_rd[(c-3)/2]) begin
            wdata     = s_d1[(c-3)/2];
            lane_we_n = s_m1[(c-3)/2];
         end else begin
            // junk that must be ignored (R8)
            wdata     = W'(rnd());
            lane_we_n = LANES'(rnd());
         end
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected<50000", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      // reset state (R10)
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", 32'(rdata_vld), 32'd0);
      check("R10", 32'(echo_en), 32'd0);
      check("R10", 32'(rdata), 32'd0);
      @(posedge clk);
      #1 rst = 1'b0;

      // R2: fill every address with full masks, then read all back
      seg_begin();
      for (int a = 0; a < DEPTH; a++)
         add_slot(1, 0, a, W'(a * 18'h0_1111 + 18'h155), '0,
                  W'(~(a * 18'h0_0707) ^ a), '0, "R2");
      for (int a = 0; a < DEPTH; a++)
         add_slot(1, 1, a, '0, '0, '0, '0, "R2");
      run_seg();

      // R3: back-to-back reads in reverse order
      seg_begin();
      for (int a = DEPTH - 1; a >= 0; a--)
         add_slot(1, 1, a, '0, '0, '0, '0, "R3");
      run_seg();

      // R7: write then read of the same address on the next K cycle, all mask pairs
      seg_begin();
      for (int k = 0; k < 16; k++)
         begin
            add_slot(1, 0, k, W'(k * 18'h0_2A3 + 18'h1_0001), LANES'(k & 3),
                     W'(k * 18'h0_0C5 + 18'h2_2000), LANES'(k >> 2), "R7");
            add_slot(1, 1, k, '0, '0, '0, '0, "R7");
         end
      run_seg();

      // R4: per-beat lane masks, read after two no-op slots
      seg_begin();
      for (int k = 0; k < 16; k++)
         begin
            add_slot(1, 0, 15 - k, W'(18'h3_0F0F ^ (k * 18'h0_1357)), LANES'(k >> 2),
                     W'(18'h0_F0F0 ^ (k * 18'h0_2468)), LANES'(k & 3), "R4");
            add_slot(0, 0, 15 - k, '0, '0, '0, '0, "R4");
            add_slot(0, 1, 15 - k, '0, '0, '0, '0, "R4");
            add_slot(1, 1, 15 - k, '0, '0, '0, '0, "R4");
         end
      run_seg();

      // R8: strobe high with write and read selects on a live address
      seg_begin();
      add_slot(1, 0, 5, 18'h1_2345, '0, 18'h2_3456, '0, "R8");
      for (int k = 0; k < 6; k++)
         add_slot(0, k & 1, 5, '0, '0, '0, '0, "R8");
      add_slot(1, 1, 5, '0, '0, '0, '0, "R8");
      run_seg();

      // R6: random mix of operations on every K cycle
      seg_begin();
      for (int k = 0; k < 120; k++)
         add_slot((rnd() % 4) != 0, rnd() & 1, int'(rnd() % DEPTH),
                  W'(rnd()), LANES'(rnd()), W'(rnd()), LANES'(rnd()), "R6");
      run_seg();

      // R10: reset with a read in flight; contents must survive
      @(negedge clk);
      cmd_n = 1'b0; is_read = 1'b1; addr = 3;
      @(negedge clk);
      cmd_n = 1'b1;
      @(posedge clk);
      #1 rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R10", 32'(rdata_vld), 32'd0);
      check("R10", 32'(echo_en), 32'd0);
      @(posedge clk);
      #1 rst = 1'b0;
      seg_begin();
      for (int a = 0; a < DEPTH; a++)
         add_slot(1, 1, a, '0, '0, '0, '0, "R10");
      run_seg();

      summary();
      $finish;
   end
endmodule